// File: doc/BRIEF.md
# Real-mode far return sequencer

This block carries out the stack side of a far return or an interrupt return when the processor runs in real-address mode. After a start strobe it issues a series of 32-bit stack pops through a request/response handshake. It captures the new instruction pointer, then the code selector, and, for an interrupt return only, a flags doubleword. It checks the new instruction pointer against the code-segment limit. If the check passes, it commits the code selector, the instruction pointer, the stack pointer (including the return immediate) and, for an interrupt return, the merged flags, all in one cycle.

The stack pointer is treated as speculative for the whole sequence. No architectural write strobe is raised until every pop has returned without fault and the limit check has passed. A pop fault or a limit violation ends the sequence with a fault pulse and no writes. Each accepted start also flushes the prefetch queue, and an accepted interrupt return releases the NMI block.

Top module: `far_ret_seq`

## Requirements
- R1: After reset the block is idle: pop_req_o, done_o, gp_fault_o, stk_fault_o and all write strobes are low.
- R2: Pops run in a fixed order: slot 0 is the instruction pointer, slot 1 the selector, and slot 2 the flags (interrupt return only). Pop k reads address esp_i+4k when ss_big_i=1. When ss_big_i=0, only the low 16 bits advance (modulo 2^16) and bits 31:16 stay as in esp_i. The request and the address hold until pop_valid_i.
- R3: Only bits 15:0 of the selector slot reach cs_sel_o; bits 31:16 of that slot are discarded.
- R4: If the popped instruction pointer is greater than cs_limit_i, gp_fault_o pulses for one cycle and no write strobe or done_o is raised. A pointer equal to the limit is accepted.
- R5: On an interrupt-return commit, flags_wdata_o takes the popped bits where the mask 0x00257FD5 is 1 and the bits of flags_i where it is 0. flags_we_o is never raised on a far return.
- R6: On commit, esp_wdata_o equals esp_i + 4*(number of pops) + imm_i when ss_big_i=1. When ss_big_i=0, the same sum is applied to bits 15:0 modulo 2^16, and bits 31:16 are unchanged.
- R7: nmi_unblock_o pulses in the cycle an interrupt-return start is accepted, and never for a far return.
- R8: pf_flush_o pulses in the cycle any start is accepted.
- R9: A pop answered with pop_fault_i=1 raises stk_fault_o in that cycle. The sequence ends with no further pop and no write strobe.
- R10: On commit, done_o, cs_we_o and esp_we_o pulse together for exactly one cycle, with eip_o equal to the popped instruction pointer.
- R11: A start strobe while a sequence is in progress is ignored; the pop count and type of the running sequence are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a return sequence (accepted when idle) |
| is_iret_i | input | 1 | 1 = interrupt return, 0 = far return |
| imm_i | input | 16 | Extra stack release added at commit |
| ss_big_i | input | 1 | Stack segment size: 1 = 32-bit ESP, 0 = 16-bit SP |
| esp_i | input | 32 | Current stack pointer |
| cs_limit_i | input | 32 | Scaled code-segment limit |
| flags_i | input | 32 | Current flags value |
| pop_req_o | output | 1 | Pop request |
| pop_addr_o | output | 32 | Stack offset of the requested pop |
| pop_valid_i | input | 1 | Pop response valid |
| pop_data_i | input | 32 | Popped doubleword |
| pop_fault_i | input | 1 | Pop response carries a stack fault |
| pf_flush_o | output | 1 | Invalidate prefetch queue |
| nmi_unblock_o | output | 1 | Release NMI blocking |
| stk_fault_o | output | 1 | Stack fault abort pulse |
| gp_fault_o | output | 1 | General-protection fault pulse (error code 0) |
| done_o | output | 1 | Commit pulse |
| eip_o | output | 32 | New instruction pointer |
| cs_sel_o | output | 16 | New code selector |
| cs_we_o | output | 1 | Load code selector |
| esp_we_o | output | 1 | Write stack pointer |
| esp_wdata_o | output | 32 | New stack pointer |
| flags_we_o | output | 1 | Write flags |
| flags_wdata_o | output | 32 | Merged flags value |

## Verification
The assertions rely on three conditions on the inputs. The surrounding pipeline keeps esp_i, cs_limit_i and flags_i steady from start until the sequence ends. It answers pop_valid_i only while pop_req_o is high. It asserts pop_fault_i only together with pop_valid_i. The bench drives every operand once, at the start negedge, and holds it for the whole sequence. Its responder waits for pop_req_o before driving a response, and it pulses the fault flag only inside a valid beat. The stimulus sweeps the return type, the stack size, the limit relation, the immediate, stack pointers close to the 16-bit wrap, the pop latency and faults on every pop slot.

// File: rtl/far_ret_pkg.sv
package far_ret_pkg;
  localparam int DW      = 32;
  localparam int SP_W    = 16;
  localparam int SEL_W   = 16;
  localparam int IMM_W   = 16;
  localparam int SLOT_N  = 3;
  localparam int IDX_W   = $clog2(SLOT_N);
  localparam int OFS_W   = IMM_W + 2;
  localparam logic [DW-1:0] FLG_LOAD_MASK = 32'h0025_7FD5;

  typedef enum logic [1:0] {ST_IDLE, ST_POP, ST_FIN} st_e;

  // slot order is the pop order on the stack
  localparam int SL_IP  = 0;
  localparam int SL_SEL = 1;
  localparam int SL_FLG = 2;

  function automatic logic [DW-1:0] stk_adv(input logic [DW-1:0] sp,
                                            input logic [OFS_W-1:0] ofs,
                                            input logic big);
    logic [SP_W-1:0] lo;
    lo = sp[SP_W-1:0] + ofs[SP_W-1:0];
    if (big) return sp + DW'(ofs);
    return {sp[DW-1:SP_W], lo};
  endfunction
endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import far_ret_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_iret_i,
  input  logic             big_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             pop_valid_i,
  input  logic             pop_fault_i,
  output st_e              st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             iret_o,
  output logic             big_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             accept_o,
  output logic             take_o,
  output logic             abort_o
);
  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             iret_q, big_q;
  logic [IMM_W-1:0] imm_q;
  logic             last;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign take_o   = (st_q == ST_POP) && pop_valid_i && !pop_fault_i;
  assign abort_o  = (st_q == ST_POP) && pop_valid_i && pop_fault_i;
  assign last     = idx_q == (iret_q ? IDX_W'(SLOT_N-1) : IDX_W'(SLOT_N-2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      iret_q <= 1'b0;
      big_q  <= 1'b0;
      imm_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_POP;
          idx_q  <= '0;
          iret_q <= is_iret_i;
          big_q  <= big_i;
          imm_q  <= imm_i;
        end
        ST_POP: begin
          if (abort_o)                st_q  <= ST_IDLE;
          else if (take_o && last)    st_q  <= ST_FIN;
          else if (take_o)            idx_q <= idx_q + 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign idx_o  = idx_q;
  assign iret_o = iret_q;
  assign big_o  = big_q;
  assign imm_o  = imm_q;
endmodule

// File: rtl/frs_capture.sv
module frs_capture
  import far_ret_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    slots_o [SLOT_N]
);
  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             slots_o[s] <= '0;
      else if (take_i && idx_i == IDX_W'(s))   slots_o[s] <= data_i;
    end
  end
endmodule

// File: rtl/frs_commit.sv
module frs_commit
  import far_ret_pkg::*;
(
  input  logic [DW-1:0]    esp_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             big_i,
  input  logic [DW-1:0]    ip_i,
  input  logic [DW-1:0]    sel_raw_i,
  input  logic [DW-1:0]    flg_raw_i,
  input  logic [DW-1:0]    flags_i,
  input  logic [DW-1:0]    limit_i,
  output logic             lim_ok_o,
  output logic [DW-1:0]    esp_o,
  output logic [DW-1:0]    flags_o,
  output logic [SEL_W-1:0] sel_o
);
  logic unused_sel_hi;

  assign lim_ok_o      = ip_i <= limit_i;
  assign esp_o         = stk_adv(esp_i, ofs_i, big_i);
  assign flags_o       = (flg_raw_i & FLG_LOAD_MASK) | (flags_i & ~FLG_LOAD_MASK);
  assign sel_o         = sel_raw_i[SEL_W-1:0];
  assign unused_sel_hi = ^sel_raw_i[DW-1:SEL_W];
endmodule

// File: rtl/far_ret_seq.sv
module far_ret_seq
  import far_ret_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_iret_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             ss_big_i,
  input  logic [DW-1:0]    esp_i,
  input  logic [DW-1:0]    cs_limit_i,
  input  logic [DW-1:0]    flags_i,
  output logic             pop_req_o,
  output logic [DW-1:0]    pop_addr_o,
  input  logic             pop_valid_i,
  input  logic [DW-1:0]    pop_data_i,
  input  logic             pop_fault_i,
  output logic             pf_flush_o,
  output logic             nmi_unblock_o,
  output logic             stk_fault_o,
  output logic             gp_fault_o,
  output logic             done_o,
  output logic [DW-1:0]    eip_o,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic             cs_we_o,
  output logic             esp_we_o,
  output logic [DW-1:0]    esp_wdata_o,
  output logic             flags_we_o,
  output logic [DW-1:0]    flags_wdata_o
);
  st_e              st;
  logic [IDX_W-1:0] idx;
  logic             iret_q, big_q, accept, take, abort, lim_ok, fin;
  logic [IMM_W-1:0] imm_q;
  logic [DW-1:0]    slots [SLOT_N];
  logic [OFS_W-1:0] rel_ofs, pop_ofs;
  logic [IDX_W:0]   n_pops;

  frs_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .is_iret_i,
    .big_i(ss_big_i), .imm_i, .pop_valid_i, .pop_fault_i,
    .st_o(st), .idx_o(idx), .iret_o(iret_q), .big_o(big_q), .imm_o(imm_q),
    .accept_o(accept), .take_o(take), .abort_o(abort)
  );

  frs_capture u_cap (
    .clk_i, .rst_ni, .take_i(take), .idx_i(idx), .data_i(pop_data_i), .slots_o(slots)
  );

  assign n_pops  = iret_q ? (IDX_W+1)'(SLOT_N) : (IDX_W+1)'(SLOT_N-1);
  assign rel_ofs = OFS_W'(imm_q) + OFS_W'({n_pops, 2'b00});
  assign pop_ofs = OFS_W'({idx, 2'b00});

  frs_commit u_cmt (
    .esp_i, .ofs_i(rel_ofs), .big_i(big_q),
    .ip_i(slots[SL_IP]), .sel_raw_i(slots[SL_SEL]), .flg_raw_i(slots[SL_FLG]),
    .flags_i, .limit_i(cs_limit_i),
    .lim_ok_o(lim_ok), .esp_o(esp_wdata_o), .flags_o(flags_wdata_o), .sel_o(cs_sel_o)
  );

  assign fin           = st == ST_FIN;
  assign pop_req_o     = st == ST_POP;
  assign pop_addr_o    = stk_adv(esp_i, pop_ofs, big_q);
  assign pf_flush_o    = accept;
  assign nmi_unblock_o = accept && is_iret_i;
  assign stk_fault_o   = abort;
  assign gp_fault_o    = fin && !lim_ok;
  assign done_o        = fin && lim_ok;
  assign cs_we_o       = done_o;
  assign esp_we_o      = done_o;
  assign flags_we_o    = done_o && iret_q;
  assign eip_o         = slots[SL_IP];
endmodule

// File: rtl/far_ret_seq_chk.sv
module far_ret_seq_chk
  import far_ret_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pop_req_o,
  input logic [DW-1:0] pop_addr_o,
  input logic          pop_valid_i,
  input logic [DW-1:0] eip_o,
  input logic [DW-1:0] cs_limit_i,
  input logic          stk_fault_o,
  input logic          gp_fault_o,
  input logic          done_o,
  input logic          cs_we_o,
  input logic          esp_we_o,
  input logic          flags_we_o
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o && !pop_valid_i |=> pop_req_o && $stable(pop_addr_o));

  assert_gp_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> !cs_we_o && !esp_we_o && !flags_we_o && !done_o);

  assert_done_in_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> eip_o <= cs_limit_i);

  assert_flags_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_o |-> done_o);

  assert_stk_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_fault_o |=> !pop_req_o && !done_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_commit_group_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, cs_we_o, esp_we_o}) inside {0, 3});
endmodule

bind far_ret_seq far_ret_seq_chk u_chk (.*);

// File: tb/far_ret_seq_tb.sv
`timescale 1ns/1ps
module far_ret_seq_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 0, is_iret_i = 0, ss_big_i = 0;
  logic [15:0] imm_i = '0;
  logic [31:0] esp_i = '0, cs_limit_i = '0, flags_i = '0;
  logic        pop_req_o, pop_valid_i = 0, pop_fault_i = 0;
  logic [31:0] pop_addr_o, pop_data_i = '0;
  logic        pf_flush_o, nmi_unblock_o, stk_fault_o, gp_fault_o, done_o;
  logic [31:0] eip_o, esp_wdata_o, flags_wdata_o;
  logic [15:0] cs_sel_o;
  logic        cs_we_o, esp_we_o, flags_we_o;
  int total = 0, bad = 0;
  localparam logic [31:0] MASK = 32'h0025_7FD5;

  always #10 clk_i = ~clk_i;

  far_ret_seq u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] adv(input logic [31:0] sp, input int ofs, input bit big);
    logic [15:0] lo;
    lo = sp[15:0] + 16'(ofs);
    return big ? sp + 32'(ofs) : {sp[31:16], lo};
  endfunction

  task automatic run_case(input bit iret, input bit big, input logic [15:0] imm,
                          input logic [31:0] esp, input logic [31:0] limit, input logic [31:0] ip,
                          input logic [15:0] sel, input logic [31:0] fnew, input logic [31:0] fold,
                          input int fault_at, input int lat, input bit poke);
    int n = iret ? 3 : 2;
    bit ok = ip <= limit;
    logic [31:0] data;
    @(negedge clk_i);
    is_iret_i = iret; ss_big_i = big; imm_i = imm; esp_i = esp;
    cs_limit_i = limit; flags_i = fold; start_i = 1;
    #1;
    check(pf_flush_o == 1'b1, "R8 flush", {31'b0, pf_flush_o}, 1);
    check(nmi_unblock_o == iret, "R7 nmi", {31'b0, nmi_unblock_o}, {31'b0, iret});
    @(negedge clk_i);
    start_i = 0;
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w < lat; w++) begin
        if (poke && k == 0 && w == 0) begin
          start_i = 1; is_iret_i = !iret;
          #1;
          check(pf_flush_o == 1'b0, "R11 busy start", {31'b0, pf_flush_o}, 0);
        end
        @(negedge clk_i);
        start_i = 0; is_iret_i = iret;
        #1;
        check(pop_req_o == 1'b1, "R2 req held", {31'b0, pop_req_o}, 1);
      end
      #1;
      check(pop_req_o == 1'b1, "R2 req", {31'b0, pop_req_o}, 1);
      check(pop_addr_o == adv(esp, 4 * k, big), "R2 addr", pop_addr_o, adv(esp, 4 * k, big));
      data = (k == 0) ? ip : (k == 1) ? {16'hC3A5 ^ sel, sel} : fnew;
      pop_valid_i = 1; pop_data_i = data; pop_fault_i = (k == fault_at);
      #1;
      check(stk_fault_o == (k == fault_at), "R9 stk fault", {31'b0, stk_fault_o}, {31'b0, (k == fault_at)});
      @(negedge clk_i);
      pop_valid_i = 0; pop_fault_i = 0;
      #1;
      if (k == fault_at) begin
        check(pop_req_o == 1'b0, "R9 abort req", {31'b0, pop_req_o}, 0);
        check({done_o, cs_we_o, esp_we_o, flags_we_o, gp_fault_o} == 5'b0, "R9 no write",
              {27'b0, done_o, cs_we_o, esp_we_o, flags_we_o, gp_fault_o}, 0);
        return;
      end
    end
    check(done_o == ok, "R10 done", {31'b0, done_o}, {31'b0, ok});
    check(gp_fault_o == !ok, "R4 gp", {31'b0, gp_fault_o}, {31'b0, !ok});
    check(cs_we_o == ok && esp_we_o == ok, "R4 cs/esp we", {30'b0, cs_we_o, esp_we_o}, {30'b0, ok, ok});
    check(flags_we_o == (ok && iret), "R5 flags we", {31'b0, flags_we_o}, {31'b0, ok && iret});
    if (ok) begin
      check(eip_o == ip, "R10 eip", eip_o, ip);
      check(cs_sel_o == sel, "R3 sel", {16'b0, cs_sel_o}, {16'b0, sel});
      check(esp_wdata_o == adv(esp, 4 * n + int'(imm), big), "R6 esp",
            esp_wdata_o, adv(esp, 4 * n + int'(imm), big));
      if (iret)
        check(flags_wdata_o == ((fnew & MASK) | (fold & ~MASK)), "R5 flags",
              flags_wdata_o, (fnew & MASK) | (fold & ~MASK));
    end
    @(negedge clk_i);
    #1;
    check(done_o == 1'b0 && gp_fault_o == 1'b0, "R10 pulse", {30'b0, done_o, gp_fault_o}, 0);
    check(pop_req_o == 1'b0, "R11 back idle", {31'b0, pop_req_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c = 0;
    logic [15:0] imms [3] = '{16'h0000, 16'h0004, 16'hFFFE};
    logic [31:0] esps [2] = '{32'h0001_FFF8, 32'h1234_0100};
    #5;
    check({pop_req_o, done_o, gp_fault_o, stk_fault_o, cs_we_o, esp_we_o, flags_we_o} == 7'b0,
          "R1 reset", {25'b0, pop_req_o, done_o, gp_fault_o, stk_fault_o, cs_we_o, esp_we_o, flags_we_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #1;
    check(pop_req_o == 1'b0 && done_o == 1'b0, "R1 idle", {30'b0, pop_req_o, done_o}, 0);
    for (int ir = 0; ir < 2; ir++)
      for (int bg = 0; bg < 2; bg++)
        for (int lc = 0; lc < 3; lc++)
          for (int im = 0; im < 3; im++)
            for (int es = 0; es < 2; es++) begin
              logic [31:0] lim = 32'h0000_8000 + 32'(c * 16);
              logic [31:0] ip  = (lc == 0) ? lim - 1 : (lc == 1) ? lim : lim + 1;
              logic [31:0] fn  = c[0] ? 32'hFFFF_FFFF : 32'h5A5A_A5A5;
              logic [31:0] fo  = c[0] ? 32'h0000_0000 : 32'hFFFF_FFFF;
              run_case(ir[0], bg[0], imms[im], esps[es], lim, ip, 16'(16'h1357 + c),
                       fn, fo, -1, c % 3, (c % 5) == 1);
              c++;
            end
    for (int ir = 0; ir < 2; ir++)
      for (int bg = 0; bg < 2; bg++)
        for (int fa = 0; fa < 2 + ir; fa++)
          run_case(ir[0], bg[0], 16'h0010, 32'h0000_FFFC, 32'hFFFF_FFFF, 32'h100,
                   16'hBEEF, 32'h1, 32'h2, fa, fa % 2, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule